// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block decides when a small microcontroller core stops its own clock and when it may run again. Software writes three request bits in one cycle: a stop bit, a sleep bit and an active-low timer bit. If no interrupt request is pending in that cycle, the block moves into sleep, timebase, watch, main-stop or sub-stop standby. While in standby it gates the CPU clock. It turns off the main oscillator, the sub oscillator, or neither, depending on the mode. It also asks the pad ring to float shared pins.

Any peripheral interrupt request, or the external wake input, ends standby when its priority level is enabled. The CPU's interrupt-enable state plays no part in this. After a wake from a mode that stopped an oscillator, the block keeps the CPU clock gated until a stabilization wait ends. For the main oscillator this wait is a power of two chosen by a 2-bit select. For the sub oscillator it is a fixed count of sub-clock ticks. A `run_on_sub` input tells the block that the core is clocked from the sub oscillator. In that case timer mode becomes watch mode and stop mode becomes sub-stop mode.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (run), `cpu_clk_en`, `main_osc_en` and `sub_osc_en` are 1, and `hiz_req` is 0.
- R2: A write (`wr_en`=1) accepted in run mode selects a mode, and the selection is registered at that clock edge. The precedence is stop bit set, then timer bit clear, then sleep bit set; with none of these, the block stays in run. The mode codes are run=0, sleep=1, timebase=2, watch=3, main-stop=4, sub-stop=5, main wait=6 and sub wait=7. When `run_on_sub`=1, stop gives sub-stop (5) and timer gives watch (3). Otherwise stop gives main-stop (4) and timer gives timebase (2).
- R3: If any qualifying request is present in the cycle of the write, the write is discarded and the block stays in run. It remains in run after the request goes away, until a new write arrives.
- R4: A request is qualifying only when its 3-bit level is not 7. A request at level 7 neither blocks entry nor ends standby.
- R5: In any standby mode (codes 1 to 5), a qualifying request ends the mode at the next clock edge. With no such request, the mode is held.
- R6: Waking from sleep or timebase returns to run at that same edge, with no wait.
- R7: Waking from watch or main-stop enters main wait (6). The CPU clock enable rises after exactly 2^4, 2^6, 2^8 or 2^10 clock cycles for `wait_sel` values 0, 1, 2 and 3 respectively, with `wait_sel` sampled at the wake edge.
- R8: Waking from sub-stop enters sub wait (7). The block returns to run at the edge where the second `sub_tick` pulse is seen, and not earlier.
- R9: `cpu_clk_en` is 1 only in run. `main_osc_en` is 0 in watch, main-stop and sub-stop. `sub_osc_en` is 0 only in sub-stop. `hiz_req` is 1 in timebase, watch, main-stop and sub-stop, and drops in the cycle the wake sequence begins.
- R10: The external wake input is sensed according to `ext_sel`: 00 is high level, 01 is low level, 10 is rising edge and 11 is falling edge. A detected edge sets a flag. The flag counts as a request until `ext_ack` clears it, and it carries the level `ext_lvl`.
- R11: Writes made outside run mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode request write strobe |
| wr_stop | input | 1 | Stop request bit |
| wr_sleep | input | 1 | Sleep request bit |
| wr_timer_n | input | 1 | Timer-mode request, active low |
| run_on_sub | input | 1 | Core runs from sub oscillator |
| wait_sel | input | 2 | Main oscillator wait select |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_lvl | input | 3*N_IRQ | Priority level per request, 3 bits each |
| ext_pin | input | 1 | External wake input (synchronous) |
| ext_sel | input | 2 | External wake sense select |
| ext_lvl | input | 3 | Priority level of external wake |
| ext_ack | input | 1 | Clears the external edge flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| hiz_req | output | 1 | Shared pin float request |
| mode | output | 3 | Current mode code |

## Verification
The bench issues random writes that mix the three request bits with both `run_on_sub` settings, so that both the precedence order and the two clock-source variants can be told apart. Some writes land on a cycle with a qualifying request and others with only level-7 requests, which separates refused entry from accepted entry. Every accepted standby is then woken with a randomly chosen peripheral and `wait_sel`, and the exact number of cycles until the CPU clock returns is counted. This distinguishes the immediate, main-wait and sub-tick exits. Directed sequences step the external input through all four sense encodings, the sticky edge flag and its clear, the level-7 external case, and a write made while already asleep.

// File: rtl/pwr_standby_pkg.sv
package pwr_standby_pkg;

    typedef enum logic [2:0] {
        PM_RUN       = 3'd0,
        PM_SLEEP     = 3'd1,
        PM_TIMEBASE  = 3'd2,
        PM_WATCH     = 3'd3,
        PM_STOP_MAIN = 3'd4,
        PM_STOP_SUB  = 3'd5,
        PM_WAKE_MAIN = 3'd6,
        PM_WAKE_SUB  = 3'd7
    } pm_mode_e;

    typedef enum logic [1:0] {
        EXT_HIGH = 2'b00,
        EXT_LOW  = 2'b01,
        EXT_RISE = 2'b10,
        EXT_FALL = 2'b11
    } ext_sense_e;

    typedef struct packed {
        logic stop;
        logic sleep;
        logic tmr_n;
    } pm_req_t;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;

    function automatic logic lvl_ok(input logic [LVL_W-1:0] lvl);
        return lvl != LVL_OFF;
    endfunction

    function automatic pm_mode_e pick_mode(input pm_req_t r, input logic on_sub);
        if (r.stop)   return on_sub ? PM_STOP_SUB : PM_STOP_MAIN;
        if (!r.tmr_n) return on_sub ? PM_WATCH : PM_TIMEBASE;
        if (r.sleep)  return PM_SLEEP;
        return PM_RUN;
    endfunction

    function automatic logic is_standby(input pm_mode_e m);
        return (m == PM_SLEEP) || (m == PM_TIMEBASE) || (m == PM_WATCH) ||
               (m == PM_STOP_MAIN) || (m == PM_STOP_SUB);
    endfunction

    function automatic logic main_off(input pm_mode_e m);
        return (m == PM_WATCH) || (m == PM_STOP_MAIN) || (m == PM_STOP_SUB);
    endfunction

    function automatic logic pins_float(input pm_mode_e m);
        return (m == PM_TIMEBASE) || (m == PM_WATCH) ||
               (m == PM_STOP_MAIN) || (m == PM_STOP_SUB);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
    import pwr_standby_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IRQ-1:0]       irq_req,
    input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
    input  logic                   ext_pin,
    input  logic [1:0]             ext_sel,
    input  logic [LVL_W-1:0]       ext_lvl,
    input  logic                   ext_ack,
    output logic                   wake_any
);

    logic [N_IRQ-1:0] qual;
    logic             pin_q;
    logic             edge_flag;
    logic             edge_now;
    logic             ext_hit;
    ext_sense_e       sense;

    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_qual
        assign qual[gi] = irq_req[gi] && lvl_ok(irq_lvl[gi*LVL_W +: LVL_W]);
    end

    assign sense = ext_sense_e'(ext_sel);

    always_comb begin
        case (sense)
            EXT_RISE: edge_now = ext_pin && !pin_q;
            EXT_FALL: edge_now = !ext_pin && pin_q;
            default:  edge_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q     <= 1'b0;
            edge_flag <= 1'b0;
        end else begin
            pin_q <= ext_pin;
            if (edge_now)
                edge_flag <= 1'b1;
            else if (ext_ack)
                edge_flag <= 1'b0;
        end
    end

    always_comb begin
        case (sense)
            EXT_HIGH: ext_hit = ext_pin;
            EXT_LOW:  ext_hit = !ext_pin;
            default:  ext_hit = edge_flag;
        endcase
    end

    assign wake_any = (|qual) || (ext_hit && lvl_ok(ext_lvl));

    // R10: a detected edge is remembered
    p_edge_sets_flag_r10: assert property (@(posedge clk) disable iff (rst)
        edge_now |=> edge_flag);

    // R10: the clear strobe removes the flag when no new edge arrives
    p_ack_clears_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (ext_ack && !edge_now) |=> !edge_flag);

endmodule

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer
    import pwr_standby_pkg::*;
#(
    parameter int EXP0     = 4,
    parameter int EXP1     = 6,
    parameter int EXP2     = 8,
    parameter int EXP3     = 10,
    parameter int SUB_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_main,
    input  logic [1:0] wait_sel,
    input  logic       run_main,
    input  logic       load_sub,
    input  logic       run_sub,
    input  logic       sub_tick,
    output logic       main_done,
    output logic       sub_done
);

    localparam int MAXE  = max4(EXP0, EXP1, EXP2, EXP3);
    localparam int CNT_W = (MAXE > 0) ? MAXE : 1;
    localparam int SUB_W = $clog2(SUB_WAIT + 1);

    logic [CNT_W-1:0] cnt;
    logic [SUB_W-1:0] scnt;

    function automatic logic [CNT_W-1:0] wait_top(input logic [1:0] s);
        case (s)
            2'd0:    return CNT_W'((1 << EXP0) - 1);
            2'd1:    return CNT_W'((1 << EXP1) - 1);
            2'd2:    return CNT_W'((1 << EXP2) - 1);
            default: return CNT_W'((1 << EXP3) - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_main) begin
            cnt <= wait_top(wait_sel);
        end else if (run_main && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scnt <= '0;
        end else if (load_sub) begin
            scnt <= '0;
        end else if (run_sub && sub_tick) begin
            scnt <= scnt + 1'b1;
        end
    end

    assign main_done = run_main && (cnt == '0);
    assign sub_done  = run_sub && sub_tick && (scnt == SUB_W'(SUB_WAIT - 1));

    // R7: the main wait counts down by one each cycle
    p_main_step_r7: assert property (@(posedge clk) disable iff (rst)
        (run_main && cnt != '0 && !load_main) |=> (cnt == $past(cnt) - 1'b1));

    // R7: a fresh wait never finishes on its first cycle
    p_main_not_instant_r7: assert property (@(posedge clk) disable iff (rst)
        load_main |=> !main_done);

    // R8: sub wait progress only moves on a sub tick
    p_sub_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (run_sub && !sub_tick && !load_sub) |=> $stable(scnt));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_standby_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  pm_req_t  req,
    input  logic     on_sub,
    input  logic     wake_any,
    input  logic     main_done,
    input  logic     sub_done,
    output pm_mode_e mode,
    output logic     load_main,
    output logic     load_sub
);

    pm_mode_e mode_nx;

    always_comb begin
        mode_nx   = mode;
        load_main = 1'b0;
        load_sub  = 1'b0;
        case (mode)
            PM_RUN: begin
                if (wr_en && !wake_any)
                    mode_nx = pick_mode(req, on_sub);
            end
            PM_SLEEP, PM_TIMEBASE: begin
                if (wake_any)
                    mode_nx = PM_RUN;
            end
            PM_WATCH, PM_STOP_MAIN: begin
                if (wake_any) begin
                    mode_nx   = PM_WAKE_MAIN;
                    load_main = 1'b1;
                end
            end
            PM_STOP_SUB: begin
                if (wake_any) begin
                    mode_nx  = PM_WAKE_SUB;
                    load_sub = 1'b1;
                end
            end
            PM_WAKE_MAIN: begin
                if (main_done)
                    mode_nx = PM_RUN;
            end
            default: begin
                if (sub_done)
                    mode_nx = PM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= PM_RUN;
        else
            mode <= mode_nx;
    end

    // R3: a write coinciding with a pending request is dropped
    p_entry_refused_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && wr_en && wake_any) |=> (mode == PM_RUN));

    // R5: standby is held while nothing qualifies
    p_stay_asleep_r5: assert property (@(posedge clk) disable iff (rst)
        (is_standby(mode) && !wake_any) |=> (mode == $past(mode)));

    // R5: a qualifying request always ends standby
    p_wake_leaves_r5: assert property (@(posedge clk) disable iff (rst)
        (is_standby(mode) && wake_any) |=> !is_standby(mode));

    // R11: writes in a non-run mode do not move the mode
    p_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (is_standby(mode) && wr_en && !wake_any) |=> $stable(mode));

endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl
    import pwr_standby_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int EXP0     = 4,
    parameter int EXP1     = 6,
    parameter int EXP2     = 8,
    parameter int EXP3     = 10,
    parameter int SUB_WAIT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_stop,
    input  logic                 wr_sleep,
    input  logic                 wr_timer_n,
    input  logic                 run_on_sub,
    input  logic [1:0]           wait_sel,
    input  logic                 sub_tick,
    input  logic [N_IRQ-1:0]     irq_req,
    input  logic [N_IRQ*3-1:0]   irq_lvl,
    input  logic                 ext_pin,
    input  logic [1:0]           ext_sel,
    input  logic [2:0]           ext_lvl,
    input  logic                 ext_ack,
    output logic                 cpu_clk_en,
    output logic                 main_osc_en,
    output logic                 sub_osc_en,
    output logic                 hiz_req,
    output logic [2:0]           mode
);

    pm_req_t  req;
    pm_mode_e cur;
    logic     wake_any;
    logic     load_main;
    logic     load_sub;
    logic     main_done;
    logic     sub_done;

    assign req = '{stop: wr_stop, sleep: wr_sleep, tmr_n: wr_timer_n};

    pwr_wake_detect #(.N_IRQ(N_IRQ)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .irq_lvl  (irq_lvl),
        .ext_pin  (ext_pin),
        .ext_sel  (ext_sel),
        .ext_lvl  (ext_lvl),
        .ext_ack  (ext_ack),
        .wake_any (wake_any)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .req       (req),
        .on_sub    (run_on_sub),
        .wake_any  (wake_any),
        .main_done (main_done),
        .sub_done  (sub_done),
        .mode      (cur),
        .load_main (load_main),
        .load_sub  (load_sub)
    );

    pwr_wait_timer #(
        .EXP0     (EXP0),
        .EXP1     (EXP1),
        .EXP2     (EXP2),
        .EXP3     (EXP3),
        .SUB_WAIT (SUB_WAIT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_main (load_main),
        .wait_sel  (wait_sel),
        .run_main  (cur == PM_WAKE_MAIN),
        .load_sub  (load_sub),
        .run_sub   (cur == PM_WAKE_SUB),
        .sub_tick  (sub_tick),
        .main_done (main_done),
        .sub_done  (sub_done)
    );

    assign cpu_clk_en  = (cur == PM_RUN);
    assign main_osc_en = !main_off(cur);
    assign sub_osc_en  = (cur != PM_STOP_SUB);
    assign hiz_req     = pins_float(cur);
    assign mode        = cur;

    // R9: the float request is gone once a wake begins
    p_hiz_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (hiz_req && wake_any) |=> !hiz_req);

    // R9: the CPU clock comes back only from a run transition
    p_cpu_return_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (mode == 3'd0));

endmodule

// File: tb/pwr_standby_ctrl_tb.sv
module pwr_standby_ctrl_tb;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en, wr_stop, wr_sleep, wr_timer_n;
    logic           run_on_sub;
    logic [1:0]     wait_sel;
    logic           sub_tick;
    logic [N-1:0]   irq_req;
    logic [N*3-1:0] irq_lvl;
    logic           ext_pin;
    logic [1:0]     ext_sel;
    logic [2:0]     ext_lvl;
    logic           ext_ack;
    logic           cpu_clk_en, main_osc_en, sub_osc_en, hiz_req;
    logic [2:0]     mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwr_standby_ctrl #(.N_IRQ(N)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_stop(wr_stop),
        .wr_sleep(wr_sleep), .wr_timer_n(wr_timer_n), .run_on_sub(run_on_sub),
        .wait_sel(wait_sel), .sub_tick(sub_tick), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .ext_pin(ext_pin), .ext_sel(ext_sel),
        .ext_lvl(ext_lvl), .ext_ack(ext_ack), .cpu_clk_en(cpu_clk_en),
        .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
        .hiz_req(hiz_req), .mode(mode)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_entry(input logic s, input logic sl, input logic tn,
                                     input logic sub);
        if (s)   return sub ? 5 : 4;
        if (!tn) return sub ? 3 : 2;
        if (sl)  return 1;
        return 0;
    endfunction

    // R9 output pattern {cpu, main, sub, hiz}
    function automatic int exp_outs(input int m);
        logic [3:0] o;
        o[3] = (m == 0);
        o[2] = !(m == 3 || m == 4 || m == 5);
        o[1] = (m != 5);
        o[0] = (m >= 2 && m <= 5);
        return int'(o);
    endfunction

    function automatic int exp_wait(input int sel);
        return 1 << (4 + 2 * sel);
    endfunction

    task automatic chk_mode(input string rq, input int m);
        chk(rq, int'(mode), m);
        chk({rq, "/R9"}, int'({cpu_clk_en, main_osc_en, sub_osc_en, hiz_req}), exp_outs(m));
    endtask

    task automatic write(input logic s, input logic sl, input logic tn);
        wr_en = 1'b1; wr_stop = s; wr_sleep = sl; wr_timer_n = tn;
        step(1);
        wr_en = 1'b0; wr_stop = 1'b0; wr_sleep = 1'b0; wr_timer_n = 1'b1;
    endtask

    task automatic pulse_ack();
        ext_ack = 1'b1; step(1); ext_ack = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; wr_en = 0; wr_stop = 0; wr_sleep = 0; wr_timer_n = 1;
        run_on_sub = 0; wait_sel = 0; sub_tick = 0; irq_req = '0;
        irq_lvl = '1; ext_pin = 0; ext_sel = 2'b10; ext_lvl = 3'd3; ext_ack = 0;
        step(3);
        rst = 1'b0;
        step(1);
        chk_mode("R1", 0);

        // rising edge wake
        write(0, 1, 1);
        chk_mode("R2", 1);
        ext_pin = 1'b1; step(1);
        chk_mode("R10", 1);
        step(1);
        chk_mode("R10", 0);
        // sticky flag refuses entry until cleared
        ext_pin = 1'b0;
        write(0, 1, 1);
        chk_mode("R10", 0);
        pulse_ack();
        write(0, 1, 1);
        chk_mode("R10", 1);
        // write while asleep has no effect
        write(1, 0, 0);
        chk_mode("R11", 1);
        // falling edge
        ext_sel = 2'b11;
        ext_pin = 1'b1; step(1);
        chk_mode("R10", 1);
        ext_pin = 1'b0; step(2);
        chk_mode("R10", 0);
        pulse_ack();
        // low level: pending at once
        ext_sel = 2'b01;
        write(0, 1, 1);
        chk_mode("R3", 0);
        ext_pin = 1'b1;
        write(0, 1, 1);
        chk_mode("R10", 1);
        ext_pin = 1'b0; step(1);
        chk_mode("R10", 0);
        // high level
        ext_sel = 2'b00;
        write(0, 1, 1);
        chk_mode("R10", 1);
        ext_pin = 1'b1; step(1);
        chk_mode("R10", 0);
        // level 7 external is ignored
        ext_lvl = 3'd7;
        write(0, 1, 1);
        chk_mode("R4", 1);
        step(2);
        chk_mode("R4", 1);
        ext_lvl = 3'd2; step(1);
        chk_mode("R5", 0);
        ext_pin = 1'b0; ext_lvl = 3'd3;
        pulse_ack();

        for (int it = 0; it < 40; it++) begin
            logic s, sl, tn, sub, blk;
            int sel, exp_m, idx, k;
            s   = ($urandom_range(0, 3) == 0);
            tn  = ($urandom_range(0, 2) != 0);
            sl  = 1'($urandom_range(0, 1));
            sub = 1'($urandom_range(0, 1));
            sel = $urandom_range(0, 3);
            blk = ($urandom_range(0, 3) == 0);
            for (int i = 0; i < N; i++) begin
                irq_req[i] = 1'($urandom_range(0, 1));
                irq_lvl[i*3 +: 3] = 3'd7;
            end
            if (blk) begin
                idx = $urandom_range(0, N - 1);
                irq_req[idx] = 1'b1;
                irq_lvl[idx*3 +: 3] = 3'($urandom_range(0, 6));
            end
            run_on_sub = sub;
            wait_sel = 2'(sel);
            write(s, sl, tn);
            exp_m = blk ? 0 : exp_entry(s, sl, tn, sub);
            chk_mode(blk ? "R3" : "R2", exp_m);
            if (blk) begin
                irq_req = '0;
                step(2);
                chk_mode("R3", 0);
            end else if (exp_m != 0) begin
                step($urandom_range(1, 4));
                chk_mode("R4", exp_m);
                idx = $urandom_range(0, N - 1);
                irq_req[idx] = 1'b1;
                irq_lvl[idx*3 +: 3] = 3'($urandom_range(0, 6));
                step(1);
                irq_req = '0;
                if (exp_m <= 2) begin
                    chk_mode("R6", 0);
                end else if (exp_m <= 4) begin
                    chk_mode("R7", 6);
                    k = 0;
                    while (cpu_clk_en == 1'b0 && k < 3000) begin
                        step(1);
                        k++;
                    end
                    chk("R7", k, exp_wait(sel));
                    chk_mode("R7", 0);
                end else begin
                    chk_mode("R8", 7);
                    step(2);
                    chk_mode("R8", 7);
                    sub_tick = 1'b1; step(1); sub_tick = 1'b0;
                    chk_mode("R8", 7);
                    step(2);
                    chk_mode("R8", 7);
                    sub_tick = 1'b1; step(1); sub_tick = 1'b0;
                    chk_mode("R8", 0);
                end
            end
            irq_req = '0;
            step(1);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule